// File: doc/BRIEF.md
# Banked MSI Interrupt Collector

This block gathers message-signalled interrupts for 256 vectors, held as 8 banks of 32 bits. An inbound memory write is presented as a 64-bit address together with a vector number. When the address equals the programmed match address and the vector is enabled, the block sets that vector's status bit. Vector n belongs to bank n>>5, at bit n&31.

Software reaches the block through a simple register port. Each bank has three 32-bit registers. The enable register decides which vectors are captured. The mask register decides which captured vectors are reported. The status register holds the captured vectors. A bank's pending word is its status with the masked bits removed. Reading a bank's status register returns that pending word and clears exactly those bits, so one read services the bank. A single interrupt line is high while any bank holds a pending bit.

Top module: `msi_collector`

## Requirements
- R1: After reset every bank has enable = 0x00000000, mask = 0xFFFFFFFF and status = 0. Both match-address registers read 0 and irq_o is 0.
- R2: Vector n (0 to 255) maps to bank n>>5, bit n&31.
- R3: Register map, using byte addresses on reg_addr:
  - 0x820 holds match address bits 31:0 and 0x824 holds bits 63:32.
  - Bank b starts at 0x828 + 12*b, with enable at +0, mask at +4 and status at +8.
  - Enable, mask and the two match registers read back the value last written.
- R4: An inbound message sets a status bit only when msg_valid is 1, msg_addr equals the 64-bit match address, and that vector's enable bit is 1. Any other message changes nothing.
- R5: A write to an enable register clears the mask bit of every vector that goes from disabled to enabled. All other mask bits keep their value.
- R6: Writing to a status register clears each status bit whose write-data bit is 1. Status bits whose write-data bit is 0 keep their value.
- R7: Reading a status register returns status AND NOT mask. The read clears exactly those returned bits; masked status bits are kept. Read data appears on reg_rdata in the cycle after reg_rd.
- R8: The following have no effect:
  - a message whose vector is 256 or more;
  - a register access to any address outside the map, including bank indices of 8 or more.
  A read of such an address returns 0.
- R9: irq_o is a register. It equals the OR over all banks of (status AND NOT mask), one cycle later.
- R10: If a message sets a bit in the same cycle that a status write or a status read clears it, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| msg_valid | input | 1 | Inbound message present |
| msg_addr | input | 64 | Inbound message target address |
| msg_vector | input | 16 | Inbound message vector number |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that reg_wr and reg_rd are never high together. Only then is a status clear caused by exactly one source. They also assume that reads never coincide with writes to the same bank. The stimulus drives one register access per cycle and returns both strobes to 0 between accesses. Messages do run in parallel with status clears, but only in the two dedicated set-versus-clear tests.

// File: rtl/msi_pkg.sv
package msi_pkg;

    // Defaults shared by the collector and its sub-blocks
    localparam int unsigned MSI_NUM_BANKS  = 8;
    localparam int unsigned MSI_BANK_BITS  = 32;
    localparam int unsigned MSI_ADDR_W     = 12;
    localparam int unsigned MSI_VEC_W      = 16;

    // Which register a register-port address selects
    typedef enum logic [2:0] {
        FLD_NONE = 3'd0,
        FLD_MLO  = 3'd1,
        FLD_MHI  = 3'd2,
        FLD_EN   = 3'd3,
        FLD_MASK = 3'd4,
        FLD_STAT = 3'd5
    } msi_fld_e;

endpackage

// File: rtl/msi_reg_decode.sv
module msi_reg_decode
    import msi_pkg::*;
#(
    parameter int unsigned ADDR_W      = MSI_ADDR_W,
    parameter int unsigned NUM_BANKS   = MSI_NUM_BANKS,
    parameter int unsigned MATCH_LO    = 32'h820,
    parameter int unsigned BANK_BASE   = 32'h828,
    parameter int unsigned BANK_STRIDE = 12,
    localparam int unsigned IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [ADDR_W-1:0] reg_addr,
    output msi_fld_e          fld_o,
    output logic [IDX_W-1:0]  idx_o
);

    localparam int unsigned MATCH_HI = MATCH_LO + 4;

    // Exact-compare decode: each bank owns three word addresses
    always_comb begin
        fld_o = FLD_NONE;
        idx_o = '0;
        if (reg_addr == ADDR_W'(MATCH_LO)) begin
            fld_o = FLD_MLO;
        end else if (reg_addr == ADDR_W'(MATCH_HI)) begin
            fld_o = FLD_MHI;
        end
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (reg_addr == ADDR_W'(BANK_BASE + b * BANK_STRIDE)) begin
                fld_o = FLD_EN;
                idx_o = IDX_W'(b);
            end else if (reg_addr == ADDR_W'(BANK_BASE + b * BANK_STRIDE + 4)) begin
                fld_o = FLD_MASK;
                idx_o = IDX_W'(b);
            end else if (reg_addr == ADDR_W'(BANK_BASE + b * BANK_STRIDE + 8)) begin
                fld_o = FLD_STAT;
                idx_o = IDX_W'(b);
            end
        end
    end

endmodule

// File: rtl/msi_msg_decode.sv
module msi_msg_decode #(
    parameter int unsigned NUM_BANKS = 8,
    parameter int unsigned BANK_BITS = 32,
    parameter int unsigned VEC_W     = 16,
    parameter int unsigned MADDR_W   = 64,
    localparam int unsigned TOTAL    = NUM_BANKS * BANK_BITS,
    localparam int unsigned BIT_W    = $clog2(BANK_BITS),
    localparam int unsigned SEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                                msg_valid,
    input  logic [MADDR_W-1:0]                  msg_addr,
    input  logic [VEC_W-1:0]                    msg_vector,
    input  logic [MADDR_W-1:0]                  match_addr,
    output logic [NUM_BANKS-1:0][BANK_BITS-1:0] set_o
);

    logic             in_range;
    logic             hit;
    logic [SEL_W-1:0] bank_sel;
    logic [BIT_W-1:0] bit_sel;

    assign in_range = (32'(msg_vector) < 32'(TOTAL));
    assign hit      = msg_valid && (msg_addr == match_addr) && in_range;
    assign bank_sel = SEL_W'(msg_vector >> BIT_W);
    assign bit_sel  = msg_vector[BIT_W-1:0];

    // One one-hot set word per bank
    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_set
        assign set_o[g] = (hit && bank_sel == SEL_W'(g))
                        ? (BANK_BITS'(1) << bit_sel) : '0;
    end

endmodule

// File: rtl/msi_bank.sv
module msi_bank #(
    parameter int unsigned BANK_BITS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_wr,
    input  logic                 mask_wr,
    input  logic                 stat_wr,
    input  logic                 stat_rd,
    input  logic [BANK_BITS-1:0] wdata,
    input  logic [BANK_BITS-1:0] set_i,
    output logic [BANK_BITS-1:0] en_o,
    output logic [BANK_BITS-1:0] mask_o,
    output logic [BANK_BITS-1:0] pend_o
);

    typedef struct packed {
        logic [BANK_BITS-1:0] en;
        logic [BANK_BITS-1:0] mask;
        logic [BANK_BITS-1:0] stat;
    } bank_st_t;

    bank_st_t             s_d, s_q;
    logic [BANK_BITS-1:0] clr;

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (en_wr) begin
            s_d.en   = wdata;
            s_d.mask = s_q.mask & ~(wdata & ~s_q.en);
        end
        if (mask_wr) begin
            s_d.mask = wdata;
        end
        if (stat_wr) begin
            clr = wdata;
        end else if (stat_rd) begin
            clr = s_q.stat & ~s_q.mask;
        end
        // A capture in the same cycle overrides any clear of that bit
        s_d.stat = (s_q.stat & ~clr) | (set_i & s_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.en   <= '0;
            s_q.mask <= '1;
            s_q.stat <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_o   = s_q.en;
    assign mask_o = s_q.mask;
    assign pend_o = s_q.stat & ~s_q.mask;

    // R4: a status bit only rises where an enabled capture was offered
    p_capture_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((s_q.stat & ~$past(s_q.stat) & ~$past(set_i & s_q.en)) == '0));

    // R5: newly enabled vectors leave the write unmasked
    p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> ((s_q.en & ~$past(s_q.en) & s_q.mask) == '0));

    // R6: write-one-to-clear with no capture pending
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && set_i == '0) |=> ((s_q.stat & $past(wdata)) == '0));

    // R7: a service read keeps only the masked status bits
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && set_i == '0) |=> (s_q.stat == ($past(s_q.stat) & $past(s_q.mask))));

    // R10: an enabled capture survives any same-cycle clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & s_q.en) != '0) |=>
            ((s_q.stat & $past(set_i & s_q.en)) == $past(set_i & s_q.en)));

endmodule

// File: rtl/msi_collector.sv
module msi_collector
    import msi_pkg::*;
#(
    parameter int unsigned NUM_BANKS   = MSI_NUM_BANKS,
    parameter int unsigned BANK_BITS   = MSI_BANK_BITS,
    parameter int unsigned ADDR_W      = MSI_ADDR_W,
    parameter int unsigned VEC_W       = MSI_VEC_W,
    parameter int unsigned MATCH_LO    = 32'h820,
    parameter int unsigned BANK_BASE   = 32'h828,
    parameter int unsigned BANK_STRIDE = 12,
    localparam int unsigned DW         = BANK_BITS,
    localparam int unsigned MADDR_W    = 2 * DW,
    localparam int unsigned IDX_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    output logic [DW-1:0]      reg_rdata,
    input  logic               msg_valid,
    input  logic [MADDR_W-1:0] msg_addr,
    input  logic [VEC_W-1:0]   msg_vector,
    output logic               irq_o
);

    typedef struct packed {
        logic [DW-1:0] mlo;
        logic [DW-1:0] mhi;
        logic [DW-1:0] rdata;
        logic          irq;
    } top_st_t;

    top_st_t    t_d, t_q;
    msi_fld_e   fld;
    logic [IDX_W-1:0] idx;
    logic       rd_go;

    logic [NUM_BANKS-1:0][BANK_BITS-1:0] set_w, en_w, mask_w, pend_w;
    logic [NUM_BANKS-1:0]                en_wr, mask_wr, stat_wr, stat_rd;
    logic                                any_pend;

    assign rd_go = reg_rd && !reg_wr;

    msi_reg_decode #(
        .ADDR_W      (ADDR_W),
        .NUM_BANKS   (NUM_BANKS),
        .MATCH_LO    (MATCH_LO),
        .BANK_BASE   (BANK_BASE),
        .BANK_STRIDE (BANK_STRIDE)
    ) u_reg_decode (
        .reg_addr (reg_addr),
        .fld_o    (fld),
        .idx_o    (idx)
    );

    msi_msg_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_BITS (BANK_BITS),
        .VEC_W     (VEC_W),
        .MADDR_W   (MADDR_W)
    ) u_msg_decode (
        .msg_valid  (msg_valid),
        .msg_addr   (msg_addr),
        .msg_vector (msg_vector),
        .match_addr ({t_q.mhi, t_q.mlo}),
        .set_o      (set_w)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic here;
        assign here       = (idx == IDX_W'(g));
        assign en_wr[g]   = reg_wr && here && (fld == FLD_EN);
        assign mask_wr[g] = reg_wr && here && (fld == FLD_MASK);
        assign stat_wr[g] = reg_wr && here && (fld == FLD_STAT);
        assign stat_rd[g] = rd_go  && here && (fld == FLD_STAT);

        msi_bank #(
            .BANK_BITS (BANK_BITS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_wr   (en_wr[g]),
            .mask_wr (mask_wr[g]),
            .stat_wr (stat_wr[g]),
            .stat_rd (stat_rd[g]),
            .wdata   (reg_wdata),
            .set_i   (set_w[g]),
            .en_o    (en_w[g]),
            .mask_o  (mask_w[g]),
            .pend_o  (pend_w[g])
        );
    end

    assign any_pend = |pend_w;

    always_comb begin
        t_d     = t_q;
        t_d.irq = any_pend;
        if (reg_wr) begin
            if (fld == FLD_MLO) t_d.mlo = reg_wdata;
            if (fld == FLD_MHI) t_d.mhi = reg_wdata;
        end
        if (rd_go) begin
            unique case (fld)
                FLD_MLO:  t_d.rdata = t_q.mlo;
                FLD_MHI:  t_d.rdata = t_q.mhi;
                FLD_EN:   t_d.rdata = en_w[idx];
                FLD_MASK: t_d.rdata = mask_w[idx];
                FLD_STAT: t_d.rdata = pend_w[idx];
                default:  t_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign reg_rdata = t_q.rdata;
    assign irq_o     = t_q.irq;

    // R9: the line follows the banks' pending words one cycle later
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        any_pend |=> irq_o);
    p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_pend |=> !irq_o);

    // R8: out-of-range vectors never reach a bank
    p_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(msg_vector) >= 32'(NUM_BANKS * BANK_BITS)) |-> (set_w == '0));

endmodule

// File: tb/msi_collector_bench.sv
module msi_collector_bench;

    localparam int NB = 8;
    localparam int BW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid = 1'b0;
    logic [63:0] msg_addr = '0;
    logic [15:0] msg_vector = '0;
    logic        irq_o;

    msi_collector u_msi_collector (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .msg_valid  (msg_valid),
        .msg_addr   (msg_addr),
        .msg_vector (msg_vector),
        .irq_o      (irq_o)
    );

    always #5 clk = ~clk;

    // Reference state, built from the requirements
    logic [31:0] m_en   [NB];
    logic [31:0] m_mask [NB];
    logic [31:0] m_stat [NB];
    logic [31:0] m_lo, m_hi;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sbq[$];

    int errors = 0;
    int checks = 0;
    logic rd_seen = 1'b0;
    logic done = 1'b0;

    localparam logic [63:0] MATCH = 64'h0000_0001_0000_1000;

    function automatic void map_addr(input logic [11:0] a, output int kind, output int b);
        int off;
        kind = 0;
        b    = 0;
        off  = int'(a) - 'h828;
        if (a == 12'h820) kind = 1;
        else if (a == 12'h824) kind = 2;
        else if (off >= 0 && off < NB * 12 && (off % 4) == 0) begin
            b    = off / 12;
            kind = 3 + (off % 12) / 4;
        end
    endfunction

    function automatic logic [31:0] model_read(input logic [11:0] a);
        int k, b;
        logic [31:0] v;
        map_addr(a, k, b);
        case (k)
            1: v = m_lo;
            2: v = m_hi;
            3: v = m_en[b];
            4: v = m_mask[b];
            5: begin
                v = m_stat[b] & ~m_mask[b];
                m_stat[b] = m_stat[b] & ~v;
            end
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
        int k, b;
        map_addr(a, k, b);
        case (k)
            1: m_lo = d;
            2: m_hi = d;
            3: begin
                m_mask[b] = m_mask[b] & ~(d & ~m_en[b]);
                m_en[b]   = d;
            end
            4: m_mask[b] = d;
            5: m_stat[b] = m_stat[b] & ~d;
            default: ;
        endcase
    endfunction

    function automatic void model_msg(input logic [63:0] a, input int vec);
        if (a == {m_hi, m_lo} && vec < NB * BW) begin
            if (m_en[vec >> 5][vec & 31])
                m_stat[vec >> 5][vec & 31] = 1'b1;
        end
    endfunction

    function automatic logic model_irq();
        logic r = 1'b0;
        for (int b = 0; b < NB; b++) r |= |(m_stat[b] & ~m_mask[b]);
        return r;
    endfunction

    function automatic logic [11:0] a_en(input int b);   return 12'(32'h828 + 12 * b);     endfunction
    function automatic logic [11:0] a_mask(input int b); return 12'(32'h828 + 12 * b + 4); endfunction
    function automatic logic [11:0] a_stat(input int b); return 12'(32'h828 + 12 * b + 8); endfunction

    // Driver tasks: start at a falling edge, end at the next falling edge
    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_read(input logic [11:0] a, input string tag);
        item_t it;
        it.exp = model_read(a);
        it.tag = tag;
        sbq.push_back(it);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic do_msg(input logic [63:0] a, input int vec);
        msg_valid = 1'b1; msg_addr = a; msg_vector = 16'(vec);
        @(negedge clk);
        msg_valid = 1'b0;
        model_msg(a, vec);
    endtask

    task automatic msg_with_w1c(input int vec, input logic [11:0] a, input logic [31:0] d);
        msg_valid = 1'b1; msg_addr = MATCH; msg_vector = 16'(vec);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        msg_valid = 1'b0; reg_wr = 1'b0;
        model_write(a, d);
        model_msg(MATCH, vec);
    endtask

    task automatic msg_with_read(input int vec, input logic [11:0] a, input string tag);
        item_t it;
        it.exp = model_read(a);
        it.tag = tag;
        sbq.push_back(it);
        msg_valid = 1'b1; msg_addr = MATCH; msg_vector = 16'(vec);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        msg_valid = 1'b0; reg_rd = 1'b0;
        model_msg(MATCH, vec);
    endtask

    task automatic check_irq(input string tag);
        logic e;
        @(negedge clk);
        e = model_irq();
        checks++;
        if (irq_o !== e) begin
            errors++;
            $display("FAIL %s: irq_o actual=%0b expected=%0b", tag, irq_o, e);
        end
    endtask

    // Monitor: compare each read result against the queued expectation
    always @(posedge clk) rd_seen <= reg_rd;

    always @(negedge clk) begin
        if (rd_seen) begin
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: read data with no expectation, actual=%08h expected=none", reg_rdata);
            end else begin
                item_t it;
                it = sbq.pop_front();
                if (reg_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%08h expected=%08h", it.tag, reg_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) begin
            m_en[b] = '0; m_mask[b] = '1; m_stat[b] = '0;
        end
        m_lo = '0; m_hi = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_irq("R1 irq after reset");
        do_read(a_en(0),   "R1 reset enable bank0");
        do_read(a_mask(0), "R1 reset mask bank0");
        do_read(a_stat(7), "R1 reset status bank7");
        do_read(a_mask(7), "R1 reset mask bank7");
        do_read(12'h820,   "R1 reset match low");
        do_read(12'h824,   "R1 reset match high");

        // R3: match registers and map
        do_write(12'h820, MATCH[31:0]);
        do_write(12'h824, MATCH[63:32]);
        do_read(12'h820, "R3 match low readback");
        do_read(12'h824, "R3 match high readback");
        do_write(a_mask(3), 32'hA5A5_0F0F);
        do_read(a_mask(3), "R3 mask bank3 readback");
        do_write(a_en(4), 32'h0000_0000);
        do_read(a_en(4), "R3 enable bank4 readback");

        // R4: message before enable is dropped
        do_msg(MATCH, 5);
        do_read(a_stat(0), "R4 disabled vector not captured");
        check_irq("R4 irq stays low when disabled");

        // R5: enabling clears the mask bit
        do_write(a_en(0), 32'h0000_0020);
        do_read(a_mask(0), "R5 mask bit5 cleared by enable");
        do_write(a_en(3), 32'h0000_0101);
        do_read(a_mask(3), "R5 mask bank3 newly enabled bits cleared");

        // R4: wrong address dropped, right address captured; R9 irq
        do_msg(MATCH ^ 64'h1_0000_0000, 5);
        check_irq("R4 wrong address ignored");
        do_msg(MATCH, 5);
        check_irq("R9 irq raised after capture");

        // R6: write-one-to-clear
        do_write(a_stat(0), 32'h0000_0001);
        check_irq("R6 zero bit write keeps status");
        do_write(a_stat(0), 32'h0000_0020);
        check_irq("R9 irq falls after clear");
        do_read(a_stat(0), "R6 status empty after clear");

        // R2 and R7: vectors 200 and 201 land in bank 6 bits 8 and 9
        do_write(a_en(6), 32'h0000_0300);
        do_write(a_mask(6), 32'hFFFF_FEFF);
        do_msg(MATCH, 200);
        do_msg(MATCH, 201);
        do_read(a_stat(6), "R7 pending hides masked bit9");
        do_read(a_stat(6), "R7 read cleared bit8 only");
        check_irq("R9 irq low with only masked status");
        do_write(a_mask(6), 32'hFFFF_FCFF);
        check_irq("R9 irq raised on unmask");
        do_read(a_stat(6), "R2 vector 201 at bank6 bit9");
        do_write(a_en(7), 32'hFFFF_FFFF);
        do_msg(MATCH, 255);
        do_read(a_stat(7), "R2 vector 255 at bank7 bit31");

        // R8: out-of-range vectors and addresses
        do_write(a_en(0), 32'h0000_0021);
        do_msg(MATCH, 256);
        do_msg(MATCH, 300);
        check_irq("R8 high vectors raise nothing");
        do_read(a_stat(0), "R8 vector 256 does not wrap to bank0");
        do_write(a_en(8), 32'hFFFF_FFFF);
        do_write(a_mask(8), 32'h0);
        do_write(12'h81C, 32'hFFFF_FFFF);
        do_read(a_en(8), "R8 bank8 enable reads zero");
        do_read(12'h81C, "R8 unmapped read zero");
        do_read(a_en(0), "R8 bank0 enable untouched");
        do_read(a_mask(7), "R8 bank7 mask untouched");
        do_read(12'h820, "R8 match low untouched");

        // R10: set beats clear in the same cycle
        msg_with_w1c(0, a_stat(0), 32'h0000_0001);
        do_read(a_stat(0), "R10 set wins over write clear");
        msg_with_read(0, a_stat(0), "R10 read during set returns old value");
        do_read(a_stat(0), "R10 set wins over read clear");
        check_irq("R9 irq low at end");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule